// File: doc/BRIEF.md
# Serial Audio Link Frame Engine (controller side)

This block is the controller end of a five-wire serial audio/control link. The codec supplies the bit clock and the block runs entirely on it. The block drives the frame sync marker and the active-low codec reset. On each frame it shifts out thirteen time slots on the outbound serial line and collects thirteen slots from the inbound line. Slot 0 is a 16-bit tag. Slots 1 to 12 each carry a 20-bit word. A frame is 256 bit clocks long.

On the parallel side the block takes one 20-bit transmit word and one valid flag for each data slot. It builds the outgoing tag from the valid flags. Each received frame is presented as twelve 20-bit words, the per-slot valid flags decoded from the incoming tag, a codec-ready bit, and a one-cycle frame-done strobe.

While the codec reset is asserted, the sync and data outputs are held low. They stay low across the rising edge of the reset, which keeps the codec out of its test modes. Frames only start a programmable number of bit clocks after the reset has been released.

Top module: `aclink_frame_engine`

## Requirements
- R1: After `rst_n` is released, `codec_rst_n` stays low for RST_LOW_CYC bit clocks and then rises. It also stays low for as long as `cold_reset` is high, and it is never low for fewer than RST_LOW_CYC clocks.
- R2: `sync` and `sdata_out` are low in every cycle in which `codec_rst_n` is low, and in the cycle in which it rises.
- R3: Once running, a frame is 256 bit clocks. `sync` is high for the 16 clocks of slot 0 (frame positions 0 to 15) and low for the other 240.
- R4: The first `sync` high cycle comes START_DELAY+1 bit clocks after `codec_rst_n` rises.
- R5: Slot 0 is sent MSB first. Its bit 15 is the OR of all `tx_valid` bits. Its bit 14-i equals `tx_valid[i]` (flag i is for slot i+1). Bits 2..0 are zero.
- R6: Data slot s (1..12) sends `tx_data[(s-1)*20 +: 20]` MSB first, and sends all zeros if `tx_valid[s-1]` is clear.
- R7: `tx_data` and `tx_valid` are sampled only at the rising edge that starts frame position 255, one clock before `sync` rises. Changes at any other time do not affect the frame that follows.
- R8: `sdata_in` is sampled on the falling edge of `bit_clk`. Incoming data slot s appears on `rx_data[(s-1)*20 +: 20]`, with the first bit received as the MSB.
- R9: `codec_ready` is bit 15 of the received slot 0, and `rx_valid[i]` is its bit 14-i. All received outputs change only at the edge that raises `frame_done`.
- R10: `frame_done` is a one-cycle pulse in the first slot-0 cycle of each frame. It marks the moment all 13 slots of the previous frame have been presented. There is no pulse for the partial frame before the first full one.
- R11: When `cold_reset` is raised while running, `codec_rst_n`, `sync` and `sdata_out` all go low at the next edge. The received outputs keep their last values, and the start sequence of R1 and R4 is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cold_reset | input | 1 | Level request to hold the codec in reset |
| tx_data | input | 240 | Transmit words, slot s at bits (s-1)*20 +: 20 |
| tx_valid | input | 12 | Transmit valid flag per data slot |
| sdata_in | input | 1 | Serial data from the codec |
| codec_rst_n | output | 1 | Active-low codec reset |
| sync | output | 1 | Frame sync, high during slot 0 |
| sdata_out | output | 1 | Serial data to the codec |
| rx_data | output | 240 | Received words, slot s at bits (s-1)*20 +: 20 |
| rx_valid | output | 12 | Valid flags decoded from the received tag |
| codec_ready | output | 1 | Ready bit from the received tag |
| frame_done | output | 1 | One-cycle strobe when a received frame is presented |

## Verification
The hardest situations to reach are a cold reset that cuts a frame in the middle, and parallel inputs that change one clock before or after the capture edge at position 255. The stimulus first waits for `frame_done` to locate position 0. From there it counts falling edges: it rewrites the transmit inputs exactly at positions 254 and 255, and it raises `cold_reset` part-way through a data slot. It does this once for shorter than the minimum reset width and once for longer. A behavioural model tracks the expected bit stream, so every serial bit and every received word is compared across those disturbances.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

    // Sequencer states for the codec reset / start-up path.
    typedef enum logic [1:0] {
        LNK_RESET = 2'd0,
        LNK_WAKE  = 2'd1,
        LNK_RUN   = 2'd2
    } link_state_e;

    // Default geometry of one frame.
    localparam int DEF_TAG_W  = 16;
    localparam int DEF_SLOT_W = 20;
    localparam int DEF_DSLOTS = 12;

endpackage

// File: rtl/aclink_reset_seq.sv
module aclink_reset_seq
    import aclink_pkg::*;
#(
    parameter int RST_LOW_CYC = 32,
    parameter int START_DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cold_reset,
    output logic codec_rst_n,
    output logic run_nxt
);

    localparam int HOLD_W = $clog2(RST_LOW_CYC + 1);
    localparam int WAIT_W = $clog2(START_DELAY + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_LOW_CYC - 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(START_DELAY - 1);

    typedef struct packed {
        link_state_e       state;
        logic [HOLD_W-1:0] hold;
        logic [WAIT_W-1:0] wait_cnt;
        logic              crst_n;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        run_nxt = 1'b0;
        unique case (s_q.state)
            LNK_RESET: begin
                s_d.crst_n = 1'b0;
                if (s_q.hold >= HOLD_LAST && !cold_reset) begin
                    s_d.state    = LNK_WAKE;
                    s_d.crst_n   = 1'b1;
                    s_d.wait_cnt = '0;
                end else if (s_q.hold < HOLD_LAST) begin
                    s_d.hold = s_q.hold + 1'b1;
                end
            end
            LNK_WAKE: begin
                if (cold_reset) begin
                    s_d.state  = LNK_RESET;
                    s_d.hold   = '0;
                    s_d.crst_n = 1'b0;
                end else if (s_q.wait_cnt == WAIT_LAST) begin
                    s_d.state = LNK_RUN;
                    run_nxt   = 1'b1;
                end else begin
                    s_d.wait_cnt = s_q.wait_cnt + 1'b1;
                end
            end
            LNK_RUN: begin
                if (cold_reset) begin
                    s_d.state  = LNK_RESET;
                    s_d.hold   = '0;
                    s_d.crst_n = 1'b0;
                end else begin
                    run_nxt = 1'b1;
                end
            end
            default: begin
                s_d.state  = LNK_RESET;
                s_d.hold   = '0;
                s_d.crst_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state    <= LNK_RESET;
            s_q.hold     <= '0;
            s_q.wait_cnt <= '0;
            s_q.crst_n   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign codec_rst_n = s_q.crst_n;

endmodule

// File: rtl/aclink_slot_timer.sv
module aclink_slot_timer #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int DSLOTS = 12,
    localparam int SL_W  = $clog2(DSLOTS + 1),
    localparam int BI_W  = $clog2(SLOT_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_nxt,
    output logic [SL_W-1:0] slot_q,
    output logic [BI_W-1:0] bidx_q,
    output logic            live_q,
    output logic [SL_W-1:0] slot_nxt,
    output logic [BI_W-1:0] bidx_nxt,
    output logic            load_nxt,
    output logic            sync
);

    localparam logic [SL_W-1:0] LAST_SLOT = SL_W'(DSLOTS);
    localparam logic [BI_W-1:0] TAG_TOP   = BI_W'(TAG_W - 1);
    localparam logic [BI_W-1:0] WORD_TOP  = BI_W'(SLOT_W - 1);
    localparam logic [BI_W-1:0] IDLE_BIT  = BI_W'(1);

    typedef struct packed {
        logic [SL_W-1:0] slot;
        logic [BI_W-1:0] bidx;
        logic            live;
        logic            sync;
    } pos_t;

    pos_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (!run_nxt) begin
            // Parked one position before the frame's last bit.
            p_d.slot = LAST_SLOT;
            p_d.bidx = IDLE_BIT;
            p_d.live = 1'b0;
        end else begin
            p_d.live = 1'b1;
            if (p_q.bidx == '0) begin
                if (p_q.slot == LAST_SLOT) begin
                    p_d.slot = '0;
                    p_d.bidx = TAG_TOP;
                end else begin
                    p_d.slot = p_q.slot + 1'b1;
                    p_d.bidx = WORD_TOP;
                end
            end else begin
                p_d.bidx = p_q.bidx - 1'b1;
            end
        end
        p_d.sync = run_nxt && (p_d.slot == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.slot <= LAST_SLOT;
            p_q.bidx <= IDLE_BIT;
            p_q.live <= 1'b0;
            p_q.sync <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign slot_q   = p_q.slot;
    assign bidx_q   = p_q.bidx;
    assign live_q   = p_q.live;
    assign slot_nxt = p_d.slot;
    assign bidx_nxt = p_d.bidx;
    assign load_nxt = run_nxt && (p_d.slot == LAST_SLOT) && (p_d.bidx == '0);
    assign sync     = p_q.sync;

endmodule

// File: rtl/aclink_tx_serializer.sv
module aclink_tx_serializer #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int DSLOTS = 12,
    localparam int SL_W  = $clog2(DSLOTS + 1),
    localparam int BI_W  = $clog2(SLOT_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_nxt,
    input  logic                     load_nxt,
    input  logic [SL_W-1:0]          slot_nxt,
    input  logic [BI_W-1:0]          bidx_nxt,
    input  logic [DSLOTS*SLOT_W-1:0] tx_data,
    input  logic [DSLOTS-1:0]        tx_valid,
    output logic                     sdata_out
);

    typedef struct packed {
        logic [DSLOTS-1:0][SLOT_W-1:0] words;
        logic [TAG_W-1:0]              tag;
        logic                          sdo;
    } tx_t;

    tx_t t_d, t_q;
    logic [SLOT_W-1:0] cur_word;

    // Word currently on the wire, chosen from the held snapshot.
    always_comb begin
        cur_word = SLOT_W'(t_q.tag);
        for (int i = 0; i < DSLOTS; i++) begin
            if (slot_nxt == SL_W'(i + 1)) cur_word = t_q.words[i];
        end
    end

    always_comb begin
        t_d = t_q;
        if (!run_nxt) begin
            t_d.words = '0;
            t_d.tag   = '0;
            t_d.sdo   = 1'b0;
        end else begin
            t_d.sdo = cur_word[bidx_nxt];
            if (load_nxt) begin
                t_d.tag            = '0;
                t_d.tag[TAG_W-1]   = |tx_valid;
                for (int i = 0; i < DSLOTS; i++) begin
                    t_d.tag[TAG_W-2-i] = tx_valid[i];
                    t_d.words[i]       = tx_valid[i] ? tx_data[i*SLOT_W +: SLOT_W] : '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.words <= '0;
            t_q.tag   <= '0;
            t_q.sdo   <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign sdata_out = t_q.sdo;

endmodule

// File: rtl/aclink_rx_deserializer.sv
module aclink_rx_deserializer #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int DSLOTS = 12,
    localparam int SL_W  = $clog2(DSLOTS + 1),
    localparam int BI_W  = $clog2(SLOT_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sdata_in,
    input  logic                     run_nxt,
    input  logic                     live_q,
    input  logic [SL_W-1:0]          slot_q,
    input  logic [BI_W-1:0]          bidx_q,
    output logic [DSLOTS*SLOT_W-1:0] rx_data,
    output logic [DSLOTS-1:0]        rx_valid,
    output logic                     codec_ready,
    output logic                     frame_done
);

    localparam logic [SL_W-1:0] LAST_SLOT = SL_W'(DSLOTS);

    typedef struct packed {
        logic [SLOT_W-2:0]             shift;
        logic [DSLOTS-1:0][SLOT_W-1:0] bufs;
        logic [TAG_W-1:0]              tag;
        logic                          armed;
        logic                          done;
        logic [DSLOTS-1:0][SLOT_W-1:0] out_data;
        logic [DSLOTS-1:0]             out_valid;
        logic                          out_ready;
    } rx_t;

    rx_t r_d, r_q;
    logic samp_q;
    logic [SLOT_W-1:0] word;

    // Falling-edge capture of the inbound line, mid bit.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= 1'b0;
        else        samp_q <= sdata_in;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        word     = {r_q.shift, samp_q};
        if (!run_nxt) begin
            r_d.armed = 1'b0;
        end else if (live_q) begin
            r_d.shift = word[SLOT_W-2:0];
            if (bidx_q == '0) begin
                if (slot_q == '0) r_d.tag = word[TAG_W-1:0];
                for (int i = 0; i < DSLOTS; i++) begin
                    if (slot_q == SL_W'(i + 1)) r_d.bufs[i] = word;
                end
                if (slot_q == LAST_SLOT) begin
                    if (r_q.armed) begin
                        r_d.done      = 1'b1;
                        r_d.out_data  = r_d.bufs;
                        r_d.out_ready = r_d.tag[TAG_W-1];
                        for (int i = 0; i < DSLOTS; i++) begin
                            r_d.out_valid[i] = r_d.tag[TAG_W-2-i];
                        end
                    end
                    r_d.armed = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data     = r_q.out_data;
    assign rx_valid    = r_q.out_valid;
    assign codec_ready = r_q.out_ready;
    assign frame_done  = r_q.done;

endmodule

// File: rtl/aclink_frame_engine.sv
module aclink_frame_engine
    import aclink_pkg::*;
#(
    parameter int TAG_W       = DEF_TAG_W,
    parameter int SLOT_W      = DEF_SLOT_W,
    parameter int DSLOTS      = DEF_DSLOTS,
    parameter int RST_LOW_CYC = 32,
    parameter int START_DELAY = 8,
    localparam int SL_W       = $clog2(DSLOTS + 1),
    localparam int BI_W       = $clog2(SLOT_W),
    localparam int DATA_BITS  = DSLOTS * SLOT_W
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 cold_reset,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic [DSLOTS-1:0]    tx_valid,
    input  logic                 sdata_in,
    output logic                 codec_rst_n,
    output logic                 sync,
    output logic                 sdata_out,
    output logic [DATA_BITS-1:0] rx_data,
    output logic [DSLOTS-1:0]    rx_valid,
    output logic                 codec_ready,
    output logic                 frame_done
);

    logic            run_nxt;
    logic [SL_W-1:0] slot_q, slot_nxt;
    logic [BI_W-1:0] bidx_q, bidx_nxt;
    logic            live_q, load_nxt;

    aclink_reset_seq #(
        .RST_LOW_CYC (RST_LOW_CYC),
        .START_DELAY (START_DELAY)
    ) u_seq (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .cold_reset  (cold_reset),
        .codec_rst_n (codec_rst_n),
        .run_nxt     (run_nxt)
    );

    aclink_slot_timer #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .DSLOTS (DSLOTS)
    ) u_timer (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .run_nxt  (run_nxt),
        .slot_q   (slot_q),
        .bidx_q   (bidx_q),
        .live_q   (live_q),
        .slot_nxt (slot_nxt),
        .bidx_nxt (bidx_nxt),
        .load_nxt (load_nxt),
        .sync     (sync)
    );

    aclink_tx_serializer #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .DSLOTS (DSLOTS)
    ) u_tx (
        .clk       (bit_clk),
        .rst_n     (rst_n),
        .run_nxt   (run_nxt),
        .load_nxt  (load_nxt),
        .slot_nxt  (slot_nxt),
        .bidx_nxt  (bidx_nxt),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .sdata_out (sdata_out)
    );

    aclink_rx_deserializer #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .DSLOTS (DSLOTS)
    ) u_rx (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .sdata_in    (sdata_in),
        .run_nxt     (run_nxt),
        .live_q      (live_q),
        .slot_q      (slot_q),
        .bidx_q      (bidx_q),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .codec_ready (codec_ready),
        .frame_done  (frame_done)
    );

endmodule

// File: rtl/aclink_frame_engine_chk.sv
module aclink_frame_engine_chk #(
    parameter int TAG_W  = 16,
    parameter int DSLOTS = 12
) (
    input logic              bit_clk,
    input logic              rst_n,
    input logic              cold_reset,
    input logic              codec_rst_n,
    input logic              sync,
    input logic              sdata_out,
    input logic              frame_done,
    input logic [DSLOTS-1:0] rx_valid,
    input logic              codec_ready
);

    logic [7:0] hi_cnt;

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n)    hi_cnt <= '0;
        else if (sync) hi_cnt <= hi_cnt + 1'b1;
        else           hi_cnt <= '0;
    end

    // R2
    quiet_in_reset_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !codec_rst_n |-> (!sync && !sdata_out));

    // R2
    quiet_at_release_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(codec_rst_n) |-> (!sync && !sdata_out));

    // R11
    cold_stop_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        cold_reset |=> (!codec_rst_n && !sync && !sdata_out));

    // R10
    done_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R10
    done_at_frame_start_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_done |-> $rose(sync));

    // R3
    sync_width_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        ($fell(sync) && codec_rst_n) |-> (hi_cnt == 8'(TAG_W)));

    // R9
    rx_hold_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !frame_done |-> ($stable(rx_valid) && $stable(codec_ready)));

endmodule

bind aclink_frame_engine aclink_frame_engine_chk #(
    .TAG_W  (TAG_W),
    .DSLOTS (DSLOTS)
) u_chk (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .cold_reset  (cold_reset),
    .codec_rst_n (codec_rst_n),
    .sync        (sync),
    .sdata_out   (sdata_out),
    .frame_done  (frame_done),
    .rx_valid    (rx_valid),
    .codec_ready (codec_ready)
);

// File: tb/aclink_frame_engine_test.sv
`timescale 1ns/1ps
module aclink_frame_engine_test;

    localparam int N_RST = 32;
    localparam int N_DLY = 8;
    localparam int WD    = 100000;

    logic         bit_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cold_reset = 1'b0;
    logic [239:0] tx_data = '0;
    logic [11:0]  tx_valid = '0;
    logic         sdata_in = 1'b0;
    logic         codec_rst_n, sync, sdata_out, codec_ready, frame_done;
    logic [239:0] rx_data;
    logic [11:0]  rx_valid;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 bit_clk = ~bit_clk;

    aclink_frame_engine #(
        .RST_LOW_CYC (N_RST),
        .START_DELAY (N_DLY)
    ) uut (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .cold_reset  (cold_reset),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .sdata_in    (sdata_in),
        .codec_rst_n (codec_rst_n),
        .sync        (sync),
        .sdata_out   (sdata_out),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .codec_ready (codec_ready),
        .frame_done  (frame_done)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_frame(input logic [15:0] tag,
                                              input logic [239:0] w,
                                              input logic [11:0] v);
        logic [255:0] f = '0;
        for (int p = 0; p < 16; p++) f[p] = tag[15-p];
        for (int s = 0; s < 12; s++)
            for (int j = 0; j < 20; j++)
                f[16 + 20*s + j] = v[s] & w[s*20 + 19 - j];
        return f;
    endfunction

    function automatic logic [15:0] tag_of(input logic [11:0] v);
        logic [15:0] t = '0;
        t[15] = |v;
        for (int i = 0; i < 12; i++) t[14-i] = v[i];
        return t;
    endfunction

    function automatic logic [239:0] rnd240();
        logic [239:0] r = '0;
        for (int k = 0; k < 8; k++) r[k*30 +: 30] = 30'($urandom());
        return r;
    endfunction

    // ---------------- behavioural reference ----------------
    int m_st = 0, m_hold = 0, m_wait = 0, m_pos = -1;
    bit m_crst = 0, m_sync = 0, m_sdo = 0, m_done = 0, m_armed = 0;
    logic [255:0] cur_f = '0, nxt_f = '0, cdc_f = '0;
    logic [15:0]  cf_tag = '0;
    logic [239:0] cf_words = '0;
    logic [239:0] exp_data = '0;
    logic [11:0]  exp_valid = '0;
    bit           exp_ready = 0;

    always @(posedge bit_clk) begin
        bit run;
        int prev, np;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_hold = 0; m_wait = 0; m_pos = -1;
            m_crst = 0; m_sync = 0; m_sdo = 0; m_done = 0; m_armed = 0;
            cur_f = '0; nxt_f = '0;
            exp_data = '0; exp_valid = '0; exp_ready = 0;
        end else begin
            run = 0;
            case (m_st)
                0: begin
                    if (m_hold >= N_RST - 1 && !cold_reset) begin
                        m_st = 1; m_crst = 1; m_wait = 0;
                    end else if (m_hold < N_RST - 1) m_hold++;
                end
                1: begin
                    if (cold_reset) begin m_st = 0; m_hold = 0; m_crst = 0; end
                    else if (m_wait == N_DLY - 1) begin m_st = 2; run = 1; end
                    else m_wait++;
                end
                default: begin
                    if (cold_reset) begin m_st = 0; m_hold = 0; m_crst = 0; end
                    else run = 1;
                end
            endcase
            prev = m_pos;
            if (!run) begin
                m_pos = -1; m_sync = 0; m_sdo = 0; m_armed = 0; m_done = 0;
                cur_f = '0; nxt_f = '0;
            end else begin
                m_done = 0;
                if (prev == 255) begin
                    if (m_armed) begin
                        m_done = 1;
                        exp_data = cf_words;
                        exp_ready = cf_tag[15];
                        for (int i = 0; i < 12; i++) exp_valid[i] = cf_tag[14-i];
                    end
                    m_armed = 1;
                end
                np = (prev == -1) ? 255 : (prev + 1) % 256;
                if (np == 255) begin
                    m_sdo = cur_f[255];
                    nxt_f = mk_frame(tag_of(tx_valid), tx_data, tx_valid);
                end else if (np == 0) begin
                    cur_f = nxt_f;
                    m_sdo = cur_f[0];
                    cf_tag = 16'($urandom());
                    cf_words = rnd240();
                    cdc_f = mk_frame(cf_tag, cf_words, 12'hFFF);
                end else begin
                    m_sdo = cur_f[np];
                end
                m_sync = (np < 16);
                m_pos = np;
            end
        end
        sdata_in <= #1 ((m_pos >= 0) ? cdc_f[m_pos] : 1'b0);
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge bit_clk) begin
        if (rst_n) begin
            chk(codec_rst_n === m_crst, "R1 codec reset", 256'(codec_rst_n), 256'(m_crst));
            chk(sync === m_sync, m_crst ? "R3 sync" : "R2 sync quiet",
                256'(sync), 256'(m_sync));
            chk(sdata_out === m_sdo,
                !m_crst ? "R2 sdata quiet" : (m_pos >= 0 && m_pos < 16) ? "R5 tag bit" :
                "R6 R7 data bit", 256'(sdata_out), 256'(m_sdo));
            chk(frame_done === m_done, "R10 frame_done", 256'(frame_done), 256'(m_done));
            chk(rx_data === exp_data, "R8 rx_data", 256'(rx_data), 256'(exp_data));
            chk({codec_ready, rx_valid} === {exp_ready, exp_valid}, "R9 tag decode",
                256'({codec_ready, rx_valid}), 256'({exp_ready, exp_valid}));
        end
    end

    always @(posedge bit_clk) begin
        if (cyc >= WD) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_done();
        do @(negedge bit_clk); while (!frame_done);
    endtask

    // R4: distance from codec reset release to first sync.
    task automatic measure_start();
        int n;
        do @(negedge bit_clk); while (!codec_rst_n);
        n = 0;
        do begin @(negedge bit_clk); n++; end while (!sync);
        chk(n == N_DLY + 1, "R4 start delay", 256'(n), 256'(N_DLY + 1));
    endtask

    initial begin
        logic [11:0] pats [6];
        pats[0] = 12'hFFF; pats[1] = 12'h000; pats[2] = 12'hA5A;
        pats[3] = 12'h001; pats[4] = 12'h800; pats[5] = 12'h3C6;

        repeat (4) @(negedge bit_clk);
        // R1: reset state of all outputs.
        chk({codec_rst_n, sync, sdata_out, frame_done, codec_ready} === 5'b0,
            "R1 reset state", 256'({codec_rst_n, sync, sdata_out, frame_done, codec_ready}),
            256'(0));
        chk(rx_data === '0 && rx_valid === '0, "R8 reset rx", 256'(rx_data), 256'(0));
        tx_valid = 12'hFFF;
        tx_data  = rnd240();
        rst_n = 1'b1;
        measure_start();

        for (int f = 0; f < 6; f++) begin
            wait_done();
            tx_valid = pats[f];
            tx_data  = rnd240();
            repeat (100) @(negedge bit_clk);
            tx_data = rnd240();
        end

        // R7: rewrite inputs at positions 254 and 255 of one frame.
        wait_done();
        repeat (254) @(negedge bit_clk);
        tx_valid = 12'h5A5; tx_data = rnd240();
        @(negedge bit_clk);
        tx_valid = 12'hFF0; tx_data = rnd240();
        wait_done();
        wait_done();

        // R11: cold reset mid-frame, shorter than the minimum width (R1).
        repeat (57) @(negedge bit_clk);
        cold_reset = 1'b1;
        repeat (10) @(negedge bit_clk);
        cold_reset = 1'b0;
        measure_start();
        wait_done();
        wait_done();

        // R11: cold reset held longer than the minimum width.
        repeat (130) @(negedge bit_clk);
        cold_reset = 1'b1;
        repeat (N_RST + 20) @(negedge bit_clk);
        cold_reset = 1'b0;
        measure_start();
        tx_valid = 12'h0F3; tx_data = rnd240();
        wait_done();
        wait_done();
        wait_done();
        repeat (3) @(negedge bit_clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule